// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that takes 9-bit words on a write clock and returns them on a read clock. The two clocks may be unrelated or may be one and the same net. Each side has two enables, and both must be active before a word moves. The read data sits in an output register. That register keeps its value whenever no word is taken. A separate output-enable input turns the data pins to high impedance.

Four active-low status flags report the fill level. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock. The almost thresholds come from two offset inputs that a separate programming block drives. While that block reports that no offsets have been loaded, both thresholds fall back to 7. Pointers pass between the clock domains in Gray code through two-stage synchronisers. As a result, a flag can be slow to clear, but it is never slow to set.

Top module: `dcfifo_flags`

## Requirements
- R1: A word is stored on a rising `wclk_i` edge only when `wr_en1_ni` is 0, `wr_en2_i` is 1 and `full_no` is 1. If either enable is inactive, the FIFO does not change.
- R2: While `full_no` is 0, write attempts store nothing. The word offered is never read out.
- R3: A word is taken on a rising `rclk_i` edge only when `rd_en1_ni` and `rd_en2_ni` are both 0 and `empty_no` is 1. Words leave in the order they were written, and each taken word appears on `rdata_o` after that edge.
- R4: While `empty_no` is 0, read attempts take nothing, and `rdata_o` keeps the last word that was validly read.
- R5: `full_no` is 0 exactly when the FIFO holds DEPTH words. It falls on the write edge that stores the last free location, and it changes only on write-clock edges.
- R6: `empty_no` is 0 exactly when the FIFO holds no word. It falls on the read edge that takes the last word, and it changes only on read-clock edges.
- R7: `aempty_no` is 0 when the FIFO holds n or fewer words, and 1 when it holds n+1 or more. With `ofs_prog_i` at 1, n is `ae_ofs_i`.
- R8: `afull_no` is 0 when the FIFO holds DEPTH−m or more words, and 1 otherwise. With `ofs_prog_i` at 1, m is `af_ofs_i`.
- R9: While `ofs_prog_i` is 0, n and m are both 7, whatever the offset inputs carry.
- R10: While `rst_ni` is 0, the FIFO is empty: `empty_no` and `aempty_no` are 0, `full_no` and `afull_no` are 1, and the output register is 0.
- R11: While `oe_ni` is 1, `rdata_o` is high impedance. While it is 0, `rdata_o` drives the output register.
- R12: When both sides run at the same time on unrelated clocks, every accepted word is read exactly once, in order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en1_ni | input | 1 | Write enable, active low |
| wr_en2_i | input | 1 | Second write enable, active high |
| wdata_i | input | DATA_W | Write data |
| rd_en1_ni | input | 1 | Read enable, active low |
| rd_en2_ni | input | 1 | Second read enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| ofs_prog_i | input | 1 | 1 when the offset inputs hold loaded values |
| ae_ofs_i | input | ADDR_W+1 | Almost-empty offset n |
| af_ofs_i | input | ADDR_W+1 | Almost-full offset m |
| rdata_o | output | DATA_W | Read data, high impedance when disabled |
| empty_no | output | 1 | Empty flag, active low, read clock |
| aempty_no | output | 1 | Almost-empty flag, active low, read clock |
| full_no | output | 1 | Full flag, active low, write clock |
| afull_no | output | 1 | Almost-full flag, active low, write clock |

## Verification
The bench fills the FIFO one word at a time, from empty to full, and then drains it. After every word it checks all four flags against the count. It checks the flags of the clock that moved the word at once. It checks the other side's flags only after the pointer has had time to cross, which tells an exact threshold apart from an off-by-one. The same fill-and-drain pass runs with the default offsets and with several loaded offset pairs, including 0 and DEPTH−1, so the edges of both threshold comparisons are covered. Single-enable attempts, writes while full and reads while empty show whether the gating of each enable works and whether the held output stays put. A free-running stream with random enables on both unrelated clocks shows whether any word is lost or duplicated across the crossing.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DCF_DEFAULT_OFS = 7;
  localparam int unsigned DCF_SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned PW     = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= gray_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  // gray to binary: each bit is the parity of itself and all higher bits
  for (genvar b = 0; b < PW; b++) begin : g_g2b
    assign bin_o[b] = ^stage_q[STAGES-1][PW-1:b];
  end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int unsigned DW = 9,
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int unsigned AW      = 4,
  parameter int unsigned DEF_OFS = 7
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en1_ni,
  input  logic          wr_en2_i,
  input  logic          ofs_prog_i,
  input  logic [AW:0]   af_ofs_i,
  input  logic [AW:0]   rptr_bin_i,
  output logic          push_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_no,
  output logic          afull_no
);
  localparam int unsigned  PW      = AW + 1;
  localparam logic [PW:0]  DEPTH_X = {2'b01, {AW{1'b0}}};

  logic [AW:0] wbin_q, wgray_q, wbin_nxt, used_nxt, m_eff;
  logic [PW:0] afull_sum;

  assign push_o    = !wr_en1_ni && wr_en2_i && full_no;
  assign wbin_nxt  = wbin_q + {{AW{1'b0}}, push_o};
  assign used_nxt  = wbin_nxt - rptr_bin_i;
  assign m_eff     = ofs_prog_i ? af_ofs_i : PW'(DEF_OFS);
  assign afull_sum = {1'b0, used_nxt} + {1'b0, m_eff};

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q   <= '0;
      wgray_q  <= '0;
      full_no  <= 1'b1;
      afull_no <= 1'b1;
    end else begin
      wbin_q   <= wbin_nxt;
      wgray_q  <= wbin_nxt ^ (wbin_nxt >> 1);
      full_no  <= !used_nxt[AW];
      afull_no <= !(afull_sum >= DEPTH_X);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;

  a_r2_no_write_when_full: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wbin_q));
  a_r8_full_implies_afull: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);
  a_r5_used_bounded: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ({1'b0, wbin_q - rptr_bin_i} <= DEPTH_X));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
  parameter int unsigned DW      = 9,
  parameter int unsigned AW      = 4,
  parameter int unsigned DEF_OFS = 7
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_en1_ni,
  input  logic          rd_en2_ni,
  input  logic          ofs_prog_i,
  input  logic [AW:0]   ae_ofs_i,
  input  logic [AW:0]   wptr_bin_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] q_o,
  output logic          empty_no,
  output logic          aempty_no
);
  localparam int unsigned PW = AW + 1;

  logic        pop;
  logic [AW:0] rbin_q, rgray_q, rbin_nxt, used_nxt, n_eff;

  assign pop      = !rd_en1_ni && !rd_en2_ni && empty_no;
  assign rbin_nxt = rbin_q + {{AW{1'b0}}, pop};
  assign used_nxt = wptr_bin_i - rbin_nxt;
  assign n_eff    = ofs_prog_i ? ae_ofs_i : PW'(DEF_OFS);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      q_o       <= '0;
      empty_no  <= 1'b0;
      aempty_no <= 1'b0;
    end else begin
      rbin_q    <= rbin_nxt;
      rgray_q   <= rbin_nxt ^ (rbin_nxt >> 1);
      if (pop) q_o <= mem_rdata_i;
      empty_no  <= (used_nxt != '0);
      aempty_no <= (used_nxt > n_eff);
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;

  a_r4_hold_when_empty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> ($stable(rbin_q) && $stable(q_o)));
  a_r7_empty_implies_aempty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);
  a_r3_pop_advances: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_en1_ni && !rd_en2_ni && empty_no) |=> (rbin_q == $past(rbin_q) + 1'b1));
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
  import dcf_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en1_ni,
  input  logic              wr_en2_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en1_ni,
  input  logic              rd_en2_ni,
  input  logic              oe_ni,
  input  logic              ofs_prog_i,
  input  logic [ADDR_W:0]   ae_ofs_i,
  input  logic [ADDR_W:0]   af_ofs_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              aempty_no,
  output logic              full_no,
  output logic              afull_no
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              push;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wptr_rd, rptr_wr;
  logic [DATA_W-1:0] mem_rdata, q;

  dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) i_mem (
    .wclk_i (wclk_i), .we_i(push), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  dcf_wr_ctl #(.AW(ADDR_W), .DEF_OFS(DCF_DEFAULT_OFS)) i_wr (
    .wclk_i, .rst_ni, .wr_en1_ni, .wr_en2_i, .ofs_prog_i, .af_ofs_i,
    .rptr_bin_i(rptr_wr), .push_o(push), .waddr_o(waddr), .wgray_o(wgray),
    .full_no, .afull_no
  );

  dcf_rd_ctl #(.DW(DATA_W), .AW(ADDR_W), .DEF_OFS(DCF_DEFAULT_OFS)) i_rd (
    .rclk_i, .rst_ni, .rd_en1_ni, .rd_en2_ni, .ofs_prog_i, .ae_ofs_i,
    .wptr_bin_i(wptr_rd), .mem_rdata_i(mem_rdata), .raddr_o(raddr),
    .rgray_o(rgray), .q_o(q), .empty_no, .aempty_no
  );

  dcf_sync #(.PW(PW), .STAGES(DCF_SYNC_STAGES)) i_sync_w2r (
    .clk_i(rclk_i), .rst_ni, .gray_i(wgray), .bin_o(wptr_rd)
  );

  dcf_sync #(.PW(PW), .STAGES(DCF_SYNC_STAGES)) i_sync_r2w (
    .clk_i(wclk_i), .rst_ni, .gray_i(rgray), .bin_o(rptr_wr)
  );

  assign rdata_o = oe_ni ? {DATA_W{1'bz}} : q;
endmodule

// File: tb/test_dcfifo_flags.sv
`timescale 1ns/1ps
module test_dcfifo_flags;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NSTREAM = 300;

  logic wclk_i = 0, rclk_i = 0, rst_ni = 0;
  logic wr_en1_ni = 1, wr_en2_i = 1, rd_en1_ni = 1, rd_en2_ni = 0, oe_ni = 0;
  logic ofs_prog_i = 0;
  logic [AW:0] ae_ofs_i = '0, af_ofs_i = '0;
  logic [DW-1:0] wdata_i = '0;
  wire  [DW-1:0] rdata_o;
  logic empty_no, aempty_no, full_no, afull_no;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 wclk_i = ~wclk_i;
  always #7 rclk_i = ~rclk_i;

  dcfifo_flags #(.DATA_W(DW), .ADDR_W(AW)) i_dcfifo_flags (
    .wclk_i, .rclk_i, .rst_ni, .wr_en1_ni, .wr_en2_i, .wdata_i,
    .rd_en1_ni, .rd_en2_ni, .oe_ni, .ofs_prog_i, .ae_ofs_i, .af_ofs_i,
    .rdata_o, .empty_no, .aempty_no, .full_no, .afull_no
  );

  function automatic logic [DW-1:0] pat(input int i);
    int t = i * 37 + 11;
    return t[DW-1:0];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put_word(input logic [DW-1:0] d);
    @(negedge wclk_i); wdata_i = d; wr_en1_ni = 0;
    @(negedge wclk_i); wr_en1_ni = 1;
  endtask

  task automatic get_word();
    @(negedge rclk_i); rd_en1_ni = 0;
    @(negedge rclk_i); rd_en1_ni = 1;
  endtask

  task automatic settle_rd(); repeat (4) @(negedge rclk_i); endtask
  task automatic settle_wr(); repeat (4) @(negedge wclk_i); endtask

  task automatic sweep(input logic prog, input int n_set, input int m_set, input int salt);
    int n_eff, m_eff;
    string rq_ae, rq_af;
    n_eff = prog ? n_set : 7;
    m_eff = prog ? m_set : 7;
    rq_ae = prog ? "R7" : "R9";
    rq_af = prog ? "R8" : "R9";
    ofs_prog_i = prog; ae_ofs_i = n_set[AW:0]; af_ofs_i = m_set[AW:0];
    settle_wr(); settle_rd();
    chk(rq_ae, "aempty at 0 words", aempty_no, 0);
    chk(rq_af, "afull at 0 words", afull_no, (0 >= DEPTH - m_eff) ? 0 : 1);
    for (int k = 1; k <= DEPTH; k++) begin
      put_word(pat(k + salt));
      chk("R5", "full after write", full_no, (k == DEPTH) ? 0 : 1);
      chk(rq_af, "afull after write", afull_no, (k >= DEPTH - m_eff) ? 0 : 1);
      settle_rd();
      chk("R6", "empty after write", empty_no, 1);
      chk(rq_ae, "aempty after write", aempty_no, (k > n_eff) ? 1 : 0);
    end
    put_word(9'h1AA);  // overflow attempt
    chk("R2", "full after overflow", full_no, 0);
    for (int k = 1; k <= DEPTH; k++) begin
      int r = DEPTH - k;
      get_word();
      chk("R3", "read order", rdata_o, pat(k + salt));
      chk("R6", "empty after read", empty_no, (r != 0) ? 1 : 0);
      chk(rq_ae, "aempty after read", aempty_no, (r > n_eff) ? 1 : 0);
      settle_wr();
      chk("R5", "full after read", full_no, 1);
      chk(rq_af, "afull after read", afull_no, (r >= DEPTH - m_eff) ? 0 : 1);
    end
    get_word();  // underflow attempt
    chk("R4", "hold on empty", rdata_o, pat(DEPTH + salt));
    chk("R2", "overflow word not stored", empty_no, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge wclk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] x;
    #23;
    chk("R10", "empty in reset", empty_no, 0);
    chk("R10", "aempty in reset", aempty_no, 0);
    chk("R10", "full in reset", full_no, 1);
    chk("R10", "afull in reset", afull_no, 1);
    chk("R10", "data in reset", rdata_o, 0);
    #10 rst_ni = 1;
    settle_wr(); settle_rd();

    // R1 single-enable attempts
    @(negedge wclk_i); wdata_i = 9'h055; wr_en1_ni = 0; wr_en2_i = 0;
    @(negedge wclk_i); wr_en1_ni = 1; wr_en2_i = 1;
    @(negedge wclk_i);
    settle_rd();
    chk("R1", "write with one enable off", empty_no, 0);
    x = 9'h0A5;
    put_word(x);
    settle_rd();
    chk("R1", "write with both enables", empty_no, 1);
    // R3 blocked read with second enable off
    @(negedge rclk_i); rd_en1_ni = 0; rd_en2_ni = 1;
    @(negedge rclk_i); rd_en1_ni = 1; rd_en2_ni = 0;
    chk("R3", "read with one enable off keeps word", empty_no, 1);
    chk("R3", "read with one enable off keeps output", rdata_o, 0);
    get_word();
    chk("R3", "first word", rdata_o, x);
    chk("R6", "empty after last read", empty_no, 0);
    // R11 output enable
    oe_ni = 1; #1;
    chk("R11", "output released", (rdata_o !== x), 1);
    oe_ni = 0; #1;
    chk("R11", "output driven", rdata_o, x);
    settle_wr();

    sweep(0, 2, 12, 0);
    sweep(1, 3, 5, 40);
    sweep(1, 0, 0, 80);
    sweep(1, 15, 15, 120);
    sweep(0, 0, 0, 160);

    // R12 concurrent stream on unrelated clocks
    ofs_prog_i = 0;
    fork
      begin
        int sent = 0;
        while (sent < NSTREAM) begin
          @(negedge wclk_i);
          if (full_no && ($urandom_range(3) != 0)) begin
            wdata_i = pat(500 + sent); wr_en1_ni = 0; sent++;
          end else wr_en1_ni = 1;
        end
        @(negedge wclk_i); wr_en1_ni = 1;
      end
      begin
        int got = 0;
        bit pend = 0;
        while (got < NSTREAM) begin
          @(negedge rclk_i);
          if (pend) begin
            chk("R12", "stream order", rdata_o, pat(500 + got));
            got++;
          end
          if (got < NSTREAM && empty_no && ($urandom_range(2) != 0)) begin
            rd_en1_ni = 0; pend = 1;
          end else begin
            rd_en1_ni = 1; pend = 0;
          end
        end
        rd_en1_ni = 1;
      end
    join
    settle_rd(); settle_wr();
    chk("R12", "no extra word after stream", empty_no, 0);
    chk("R12", "not full after stream", full_no, 1);

    // R10 reset while holding data
    for (int i = 0; i < 5; i++) put_word(pat(900 + i));
    settle_rd();
    @(negedge wclk_i); #2 rst_ni = 0; #3;
    chk("R10", "empty on reset", empty_no, 0);
    chk("R10", "aempty on reset", aempty_no, 0);
    chk("R10", "full on reset", full_no, 1);
    chk("R10", "afull on reset", afull_no, 1);
    chk("R10", "data on reset", rdata_o, 0);
    #20 rst_ni = 1;
    settle_rd(); settle_wr();
    chk("R10", "still empty after reset", empty_no, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule